// File: doc/BRIEF.md
# Cascadable Vectored Interrupt Controller

This block collects up to eight interrupt request lines from peripherals. It catches each rising edge and holds it as pending until the processor takes it. It ranks the pending, unmasked lines by fixed priority and raises one interrupt output toward the processor.

The processor answers with two active-low acknowledge pulses. The first pulse commits the winning line: the line moves into service and the interrupt output drops. The second pulse puts that line's vector (a programmable base plus the line index) on an 8-bit tri-state data bus.

A small write-only register port sets three things: the per-line mask, the vector base, and whether one line serves as the cascade input from a second controller. The same port also takes the end-of-interrupt command, which closes the service of the highest-priority in-service line.

Top module: `vic_top`

## Requirements
- R1: A rising edge on `irqIn[i]` (after a two-flop synchroniser) sets that line pending. With the line unmasked and nothing in service, `intOut` is high after the third rising clock edge that follows the input change. A line held high after it has been taken does not raise `intOut` again.
- R2: Register address 0 holds the mask, where bit i = 1 masks line i. Reset value is 0xFF. A masked pending line never raises `intOut`. Clearing its mask bit raises `intOut` on the clock edge of the write.
- R3: Among eligible pending lines, the lowest index wins, and its vector is base + index. The base is register address 1, reset value 0x20.
- R4: The first falling edge of `intaN`, sampled on a clock edge, drops `intOut` from that edge on. The same edge moves the winning line from pending to in-service.
- R5: On the second falling edge of `intaN`, `busEn` goes high and `dataBus` carries the vector for as long as `intaN` stays low. At every other time `busEn` is low and `dataBus` is high-impedance.
- R6: A pending line whose index is equal to or greater than the lowest in-service index does not raise `intOut`. A line with a smaller index does raise it, so service can nest.
- R7: Writing 0x20 to address 2 clears the lowest-index in-service bit. This re-enables the lines it blocked.
- R8: If no line is eligible at the first acknowledge pulse (for example, the line was masked after `intOut` rose), the vector is base + 7. No line is put in service, and the withdrawn line stays pending.
- R9: A non-zero write to address 3 makes line 2 the cascade input. When line 2 wins, `slaveSel` is high from the first acknowledge pulse until `intaN` rises after the second pulse, and `busEn` stays low.
- R10: After reset, `intOut`, `busEn` and `slaveSel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Asynchronous interrupt request lines, rising-edge captured |
| intaN | input | 1 | Active-low acknowledge from the processor |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 mask, 1 base, 2 command, 3 cascade enable |
| regWdata | input | 8 | Register write data |
| intOut | output | 1 | Interrupt request to the processor |
| dataBus | output | 8 | Tri-state vector bus |
| busEn | output | 1 | High while the block drives `dataBus` |
| slaveSel | output | 1 | Cascade slave selected for this acknowledge |

## Verification
A request edge needs three clock edges to show on `intOut`: two synchroniser flops and the pending register. The bench therefore checks `intOut` as still low after two edges and high after the third. Acknowledge and register effects are combinational from registered state, so they are due right after the sampling edge. The bench drives every input on the falling clock edge and samples one nanosecond after the following rising edge. For `busEn` falling, it samples one nanosecond after `intaN` rises.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_BASE = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;
  localparam logic [1:0] ADDR_CASC = 2'd3;
  localparam logic [7:0] CMD_EOI   = 8'h20;

  typedef struct packed {
    logic freeze;      // first acknowledge pulse accepted
    logic drivePhase;  // second pulse low: vector may go on the bus
    logic seqActive;   // acknowledge sequence in progress
  } vicStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT2, ST_DRIVE} ackState_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter int CASCADE_LINE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [VEC_W-1:0] regWdata,
  input  vicStrobe_t       st,
  output logic             anyElig,
  output logic             busEn,
  output logic             slaveSel,
  output logic [VEC_W-1:0] vecOut
);
  localparam int IDX_W = $clog2(LINES);
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(LINES - 1);
  localparam logic [VEC_W-1:0] BASE_RST = VEC_W'(32);

  logic [LINES-1:0] syncA, syncB, prevIrq, edgeDet;
  logic [LINES-1:0] pendingQ, inService, maskQ;
  logic [LINES-1:0] allowed, eligible, takeMask, eoiMask;
  logic [VEC_W-1:0] baseQ;
  logic             cascEn, eoiWr, frozenSpur;
  logic [IDX_W-1:0] winIdx, frozenIdx;

  // Input synchroniser and rising-edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevIrq <= '0;
    end else begin
      syncA   <= irqIn;
      syncB   <= syncA;
      prevIrq <= syncB;
    end
  end
  assign edgeDet = syncB & ~prevIrq;

  // Register port
  assign eoiWr = regWr && (regAddr == ADDR_CMD) && (regWdata == CMD_EOI);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '1;
      baseQ  <= BASE_RST;
      cascEn <= 1'b0;
    end else if (regWr) begin
      case (regAddr)
        ADDR_MASK: maskQ  <= regWdata[LINES-1:0];
        ADDR_BASE: baseQ  <= regWdata;
        ADDR_CASC: cascEn <= |regWdata;
        default: ;
      endcase
    end
  end

  // Lines above the highest-priority in-service line are blocked
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      seen = seen | inService[i];
      allowed[i] = ~seen;
    end
  end
  assign eligible = pendingQ & ~maskQ & allowed;

  // Fixed priority: lowest index wins
  always_comb begin
    winIdx  = '0;
    anyElig = 1'b0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winIdx  = IDX_W'(i);
        anyElig = 1'b1;
      end
    end
  end

  // End-of-interrupt target: lowest-index in-service bit
  always_comb begin
    logic found;
    found   = 1'b0;
    eoiMask = '0;
    for (int i = 0; i < LINES; i++) begin
      if (inService[i] && !found) begin
        eoiMask[i] = eoiWr;
        found      = 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_take
      assign takeMask[g] = st.freeze && anyElig && (winIdx == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ   <= '0;
      inService  <= '0;
      frozenIdx  <= SPUR_IDX;
      frozenSpur <= 1'b1;
    end else begin
      pendingQ  <= (pendingQ & ~takeMask) | edgeDet;
      inService <= (inService & ~eoiMask) | takeMask;
      if (st.freeze) begin
        frozenIdx  <= anyElig ? winIdx : SPUR_IDX;
        frozenSpur <= !anyElig;
      end
    end
  end

  assign vecOut   = baseQ + VEC_W'(frozenIdx);
  assign slaveSel = st.seqActive && cascEn && !frozenSpur &&
                    (frozenIdx == IDX_W'(CASCADE_LINE));
  assign busEn    = st.drivePhase && !slaveSel;

  p_taken_in_service_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.freeze && anyElig) |=> inService[$past(winIdx)]);

  p_eoi_clears_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWr && (inService != '0) && !st.freeze) |=>
      ($countones(inService) == $countones($past(inService)) - 1));

  p_spurious_no_service_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.freeze && !anyElig && !eoiWr) |=> $stable(inService));
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intaN,
  input  logic       anyElig,
  output logic       intOut,
  output vicStrobe_t st
);
  ackState_t stateQ, stateD;
  logic      prevInta, ackFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      prevInta <= 1'b1;
    end else begin
      stateQ   <= stateD;
      prevInta <= intaN;
    end
  end
  assign ackFall = prevInta && !intaN;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (ackFall) stateD = ST_WAIT2;
      ST_WAIT2: if (ackFall) stateD = ST_DRIVE;
      ST_DRIVE: if (intaN)   stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  assign intOut        = (stateQ == ST_IDLE) && anyElig;
  assign st.freeze     = (stateQ == ST_IDLE) && ackFall;
  assign st.drivePhase = (stateQ == ST_DRIVE) && !intaN;
  assign st.seqActive  = (stateQ != ST_IDLE);

  p_drive_after_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DRIVE) |-> ($past(stateQ) != ST_IDLE));
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter int CASCADE_LINE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  logic             intaN,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [VEC_W-1:0] regWdata,
  output logic             intOut,
  output logic [VEC_W-1:0] dataBus,
  output logic             busEn,
  output logic             slaveSel
);
  vicStrobe_t       st;
  logic             anyElig;
  logic [VEC_W-1:0] vecOut;

  vic_control u_ctrl (
    .clk(clk), .rstN(rstN), .intaN(intaN), .anyElig(anyElig),
    .intOut(intOut), .st(st)
  );

  vic_datapath #(.LINES(LINES), .VEC_W(VEC_W), .CASCADE_LINE(CASCADE_LINE)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .st(st), .anyElig(anyElig), .busEn(busEn),
    .slaveSel(slaveSel), .vecOut(vecOut)
  );

  assign dataBus = busEn ? vecOut : 'z;

  p_bus_needs_ack_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    busEn |-> !intaN);

  p_int_drops_on_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!intaN && $past(intaN)) |=> !intOut);

  p_slave_owns_bus_r9: assert property (@(posedge clk) disable iff (!rstN)
    slaveSel |-> !busEn);
endmodule

// File: tb/vic_top_test.sv
module vic_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       intaN = 1'b1;
  logic       regWr = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic       intOut, busEn, slaveSel;
  wire  [7:0] dataBus;
  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;  // 125 MHz

  vic_top uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .intaN(intaN), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .intOut(intOut), .dataBus(dataBus),
    .busEn(busEn), .slaveSel(slaveSel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    tick(1);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic raise(input int line);
    @(negedge clk);
    irqIn[line] = 1'b1;
  endtask

  task automatic ackSeq(input logic [7:0] expVec, input logic slave, input string req);
    @(negedge clk); intaN = 1'b0;
    tick(1);
    check("R4 int low after first pulse", {7'd0, intOut}, 8'd0);
    check({req, " slaveSel after pulse 1"}, {7'd0, slaveSel}, {7'd0, slave});
    @(negedge clk); intaN = 1'b1;
    @(negedge clk); intaN = 1'b0;
    tick(1);
    check({req, " busEn in pulse 2"}, {7'd0, busEn}, {7'd0, !slave});
    if (!slave) check({req, " vector"}, dataBus, expVec);
    else check("R9 slaveSel in pulse 2", {7'd0, slaveSel}, 8'd1);
    @(negedge clk); intaN = 1'b1;
    #1;
    check("R5 busEn off after pulse 2", {7'd0, busEn}, 8'd0);
    tick(1);
    check("R9 slaveSel off after sequence", {7'd0, slaveSel}, 8'd0);
  endtask

  task automatic t_reset();
    check("R10 intOut", {7'd0, intOut}, 8'd0);
    check("R10 busEn", {7'd0, busEn}, 8'd0);
    check("R10 slaveSel", {7'd0, slaveSel}, 8'd0);
    irqIn[4] = 1'b1;  // reset mask is all ones (R2)
    tick(6);
    check("R2 reset mask blocks", {7'd0, intOut}, 8'd0);
    @(negedge clk); irqIn = '0;
    tick(4);
  endtask

  task automatic t_edge();
    regWrite(2'd0, 8'h00);
    // line 4 is pending from reset test; take it first
    tick(1);
    check("R2 unmask raises", {7'd0, intOut}, 8'd1);
    ackSeq(8'h24, 1'b0, "R3");
    regWrite(2'd2, 8'h20);
    tick(1);
    check("R1 idle before edge", {7'd0, intOut}, 8'd0);
    raise(3);
    tick(2);
    check("R1 not yet after two edges", {7'd0, intOut}, 8'd0);
    tick(1);
    check("R1 raised after three edges", {7'd0, intOut}, 8'd1);
    ackSeq(8'h23, 1'b0, "R5");
    regWrite(2'd2, 8'h20);
    tick(4);
    check("R1 held level not recaptured", {7'd0, intOut}, 8'd0);
    @(negedge clk); irqIn = '0;
    tick(4);
  endtask

  task automatic t_mask();
    regWrite(2'd0, 8'h20);
    raise(5);
    tick(6);
    check("R2 masked line silent", {7'd0, intOut}, 8'd0);
    regWrite(2'd0, 8'h00);
    #1;
    check("R2 unmasked line raises", {7'd0, intOut}, 8'd1);
    ackSeq(8'h25, 1'b0, "R5");
    regWrite(2'd2, 8'h20);
    @(negedge clk); irqIn = '0;
    tick(4);
  endtask

  task automatic t_prio();
    @(negedge clk); irqIn[6] = 1'b1; irqIn[1] = 1'b1;
    tick(4);
    check("R3 two pending raise", {7'd0, intOut}, 8'd1);
    ackSeq(8'h21, 1'b0, "R3 lowest index");
    tick(2);
    check("R6 lower priority blocked", {7'd0, intOut}, 8'd0);
    raise(0);
    tick(4);
    check("R6 higher priority nests", {7'd0, intOut}, 8'd1);
    ackSeq(8'h20, 1'b0, "R6 nested vector");
    regWrite(2'd2, 8'h20);
    tick(1);
    check("R7 first EOI keeps line 1 blocking", {7'd0, intOut}, 8'd0);
    regWrite(2'd2, 8'h20);
    tick(1);
    check("R7 second EOI releases line 6", {7'd0, intOut}, 8'd1);
    ackSeq(8'h26, 1'b0, "R3 remaining line");
    regWrite(2'd2, 8'h20);
    @(negedge clk); irqIn = '0;
    tick(4);
  endtask

  task automatic t_spurious();
    regWrite(2'd1, 8'h40);
    raise(4);
    tick(4);
    check("R1 line 4 raised", {7'd0, intOut}, 8'd1);
    regWrite(2'd0, 8'h10);
    tick(1);
    check("R8 withdrawn drops int", {7'd0, intOut}, 8'd0);
    ackSeq(8'h47, 1'b0, "R8 spurious");
    regWrite(2'd0, 8'h00);
    tick(1);
    check("R8 withdrawn line still pending", {7'd0, intOut}, 8'd1);
    ackSeq(8'h44, 1'b0, "R3 new base");
    regWrite(2'd2, 8'h20);
    @(negedge clk); irqIn = '0;
    regWrite(2'd1, 8'h20);
    tick(4);
  endtask

  task automatic t_cascade();
    regWrite(2'd3, 8'h01);
    raise(2);
    tick(4);
    check("R9 cascade line raises", {7'd0, intOut}, 8'd1);
    ackSeq(8'h00, 1'b1, "R9 slave");
    regWrite(2'd2, 8'h20);
    regWrite(2'd3, 8'h00);
    @(negedge clk); irqIn = '0;
    tick(4);
    raise(2);
    tick(4);
    ackSeq(8'h22, 1'b0, "R9 cascade off drives bus");
    regWrite(2'd2, 8'h20);
    @(negedge clk); irqIn = '0;
    tick(4);
  endtask

  initial begin : watchdog
    #800000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    @(negedge clk); rstN = 1'b1;
    irqIn[4] = 1'b1;
    tick(6);
    t_edge();
    t_mask();
    t_prio();
    t_spurious();
    t_cascade();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule